// File: doc/BRIEF.md
# Tuner Synthesizer Register Slave on a Two-Wire Serial Bus

This block is the serial control port of a tuner frequency synthesizer. A host on a two-wire bus (a clock line and an open-drain data line) sends write telegrams that load a 15-bit loop divider word, a 7-bit control field and a 3-bit band-port field. It sends read telegrams to fetch a status byte that reports a sticky power-on flag and the loop lock flag. Both bus lines are oversampled by the block's own system clock. The block has a single data output: a pull-down enable for the data line.

After a matching address byte, each data byte that follows is taken as the first byte of a pair. Its most significant bit selects the pair type. A 0 selects a divider pair. A 1 selects a control/band pair. Pairs may arrive in either order within one telegram. A register changes only when the second byte of its pair has been received and acknowledged.

No stream interface is present. The bus runs at the host's pace and the slave never stretches the clock, so there is no back-pressure path. All other pins are plain level signals.

Top module: `tuner_i2c_regs`

## Requirements
- R1: A start (data falling while clock is high) begins address reception from any state, including in the middle of a telegram, and releases the data line. A stop (data rising while clock is high) returns the slave to idle with the data line released.
- R2: The address byte is sent MSB first as binary 1,1,0,0,0,A1,A0,RW, where A1/A0 must equal `addr_sel[1]`/`addr_sel[0]`. On a match the slave pulls data low through the ninth clock. RW=0 selects a write and RW=1 selects a read.
- R3: On an address mismatch the slave never pulls the data line low until the next start, and the bytes that follow change no register.
- R4: A write data byte whose bit 7 is 0 opens a divider pair. Its bits 6..0 become `div_word[14:8]` and the next byte becomes `div_word[7:0]`.
- R5: A write data byte whose bit 7 is 1 opens a control pair. Its bits 6..0 become `ctrl[6:0]`. Bits 2..0 of the next byte become `band[2:0]`, with bit 2 the high port, bit 1 the mid port and bit 0 the low port.
- R6: The third data byte of a telegram is classified again by its bit 7, so divider-then-control, control-then-divider, divider-only and control-only telegrams all load correctly.
- R7: A pair cut short by a stop or a repeated start leaves all registers unchanged. The next telegram starts a fresh pair.
- R8: Every write data byte after a matching address is acknowledged during its ninth clock.
- R9: In a read, the slave shifts out the status byte MSB first: bit 7 is the power-on flag, bit 6 is `lock_i`, and bits 5..0 are 0. It repeats the status byte while the host acknowledges. After a host not-acknowledge it keeps the line released.
- R10: The power-on flag is 1 after reset and after any cycle with `por_event` high. A host not-acknowledge that ends a read clears it. If both happen in the same cycle, the set wins.
- R11: The slave changes its data pull-down only in response to a clock falling edge, a start or a stop, never while the clock is high.
- R12: After reset, `div_word`, `ctrl` and `band` are 0, the data line is released, and the power-on flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| addr_sel | input | 2 | Pin-selected low address bits A1,A0 |
| lock_i | input | 1 | Loop lock flag, reported in status bit 6 |
| por_event | input | 1 | Power-on or undervoltage event, sets the power-on flag |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| div_word | output | 15 | Loop divider word |
| ctrl | output | 7 | Control field from the control byte bits 6..0 |
| band | output | 3 | Band ports: high, mid, low |

## Verification
The two functions that can fall in the same cycle are the power-on flag being set by `por_event` and being cleared by the read-ending not-acknowledge. The bench provokes this by holding `por_event` high across the whole ninth clock of a final status byte. It judges the result by reading status again and expecting bit 7 still at 1. A later read with no event is then expected to find the flag cleared. The reference model also tracks pair steering against every byte, so a stop or a repeated start falling between the two bytes of a pair is checked against unchanged registers on every clock.

// File: rtl/tuner_i2c_pkg.sv
`timescale 1ns/1ps
package tuner_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam logic [4:0] ADDR_FIXED = 5'b11000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/tuner_i2c_sync.sv
`timescale 1ns/1ps
module tuner_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p,
  output logic sda_s
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_q, sda_q, scl_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[0] <= 1'b1;
          sda_ff[0] <= 1'b1;
        end else begin
          scl_ff[0] <= scl_i;
          sda_ff[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tuner_i2c_engine.sv
`timescale 1ns/1ps
module tuner_i2c_engine
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              sda_s,
  input  logic [1:0]        addr_sel,
  input  logic [BYTE_W-1:0] status,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_end
);
  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic              rw_q;
  logic              pull_q;
  logic              stb_q;
  logic              rd_end_q;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_FIXED, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      pull_q   <= 1'b0;
      stb_q    <= 1'b0;
      rd_end_q <= 1'b0;
    end else begin
      stb_q    <= 1'b0;
      rd_end_q <= 1'b0;
      if (start_p) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_p) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise && cnt_q < CNT_W'(BYTE_W)) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  pull_q  <= 1'b1;
                  rw_q    <= sh_q[0];
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else begin
                pull_q  <= 1'b1;
                state_q <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q    <= {status[BYTE_W-2:0], 1'b0};
                pull_q  <= ~status[BYTE_W-1];
                state_q <= ST_RD_DATA;
              end else begin
                pull_q  <= 1'b0;
                state_q <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              pull_q  <= 1'b0;
              stb_q   <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall) begin
              if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                pull_q  <= 1'b0;
                state_q <= ST_RD_ACK;
              end else begin
                pull_q <= ~tx_q[BYTE_W-1];
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise && sda_s) begin
              rd_end_q <= 1'b1;
              state_q  <= ST_SKIP;
            end else if (scl_fall) begin
              tx_q    <= {status[BYTE_W-2:0], 1'b0};
              pull_q  <= ~status[BYTE_W-1];
              cnt_q   <= '0;
              state_q <= ST_RD_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = pull_q;
  assign wr_stb   = stb_q;
  assign wr_data  = sh_q;
  assign rd_end   = rd_end_q;

  AST_PULL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> $past(scl_fall || start_p || stop_p)); // R11
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (!pull_q && state_q == ST_ADDR)); // R1
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !pull_q); // R3
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_q, rd_end_q})); // R8
endmodule

// File: rtl/tuner_reg_file.sv
`timescale 1ns/1ps
module tuner_reg_file
  import tuner_i2c_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int CTRL_W = 7,
  parameter int BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_end,
  input  logic              por_event,
  input  logic              lock_i,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl,
  output logic [BAND_W-1:0] band,
  output logic [BYTE_W-1:0] status
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int PAD_W = BYTE_W - 2;

  logic [BYTE_W-1:0] hold_q;
  logic              second_q;
  logic [DIV_W-1:0]  div_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [BAND_W-1:0] band_q;
  logic              por_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      second_q <= 1'b0;
      div_q    <= '0;
      ctrl_q   <= '0;
      band_q   <= '0;
    end else if (start_p || stop_p) begin
      second_q <= 1'b0;
    end else if (wr_stb) begin
      if (!second_q) begin
        hold_q   <= wr_data;
        second_q <= 1'b1;
      end else begin
        second_q <= 1'b0;
        if (hold_q[BYTE_W-1]) begin
          ctrl_q <= hold_q[CTRL_W-1:0];
          band_q <= wr_data[BAND_W-1:0];
        end else begin
          div_q <= {hold_q[HI_W-1:0], wr_data};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         por_q <= 1'b1;
    else if (por_event) por_q <= 1'b1;
    else if (rd_end)    por_q <= 1'b0;
  end

  assign div_word = div_q;
  assign ctrl     = ctrl_q;
  assign band     = band_q;
  assign status   = {por_q, lock_i, {PAD_W{1'b0}}};

  AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(div_q)); // R7
  AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(ctrl_q) && $stable(band_q))); // R7
  AST_POR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    por_event |=> por_q); // R10
  AST_POR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && !por_event) |=> !por_q); // R10
endmodule

// File: rtl/tuner_i2c_regs.sv
`timescale 1ns/1ps
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 15,
  parameter int CTRL_W      = 7,
  parameter int BAND_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic              por_event,
  output logic              sda_pull_o,
  output logic [DIV_W-1:0]  div_word,
  output logic [CTRL_W-1:0] ctrl,
  output logic [BAND_W-1:0] band
);
  logic scl_rise, scl_fall, start_p, stop_p, sda_s;
  logic wr_stb, rd_end;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] status;

  tuner_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s)
  );

  tuner_i2c_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s), .addr_sel(addr_sel),
    .status(status), .sda_pull(sda_pull_o), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_end(rd_end)
  );

  tuner_reg_file #(.DIV_W(DIV_W), .CTRL_W(CTRL_W), .BAND_W(BAND_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_end(rd_end),
    .por_event(por_event), .lock_i(lock_i),
    .div_word(div_word), .ctrl(ctrl), .band(band), .status(status)
  );
endmodule

// File: tb/sim_tuner_i2c_regs.sv
`timescale 1ns/1ps
module sim_tuner_i2c_regs;
  localparam int H = 16;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b10;
  logic lock = 1'b1;
  logic por_ev = 1'b0;
  logic pull;
  logic [14:0] div_word;
  logic [6:0] ctrl;
  logic [2:0] band;
  wire sda_bus = sda_m & ~pull;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit running = 0;
  bit skip = 0;

  logic [14:0] exp_div = '0;
  logic [6:0]  exp_ctrl = '0;
  logic [2:0]  exp_band = '0;
  bit          exp_por = 1;
  bit          m_second = 0;
  logic [7:0]  m_hold = '0;

  always #4 clk = ~clk;

  tuner_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .lock_i(lock), .por_event(por_ev),
    .sda_pull_o(pull), .div_word(div_word), .ctrl(ctrl), .band(band)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of the register outputs against the reference model (R4 R5 R6 R7)
  always @(negedge clk) begin
    if (rst_n && running && !skip) begin
      chk(div_word == exp_div, "R4 div_word", int'(div_word), int'(exp_div));
      chk({ctrl, band} == {exp_ctrl, exp_band}, "R5 ctrl/band",
          int'({ctrl, band}), int'({exp_ctrl, exp_band}));
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] d);
    if (!m_second) begin
      m_hold = d;
      m_second = 1;
    end else begin
      if (m_hold[7]) begin
        exp_ctrl = m_hold[6:0];
        exp_band = d[2:0];
      end else begin
        exp_div = {m_hold[6:0], d};
      end
      m_second = 0;
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b0; wait_n(H);
    scl_m = 1'b0; wait_n(Q);
    m_second = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(H);
    sda_m = 1'b1; wait_n(H);
    m_second = 0;
  endtask

  task automatic send_bit(input bit b);
    sda_m = b; wait_n(Q);
    scl_m = 1'b1; wait_n(H);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, input bit exp_ack,
                            input bit is_data, input string req);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(H/2);
    chk(pull == exp_ack, req, int'(pull), int'(exp_ack));
    wait_n(H/2);
    skip = 1;
    scl_m = 1'b0; wait_n(Q);
    if (exp_ack && is_data) model_byte(d);
    skip = 0;
  endtask

  task automatic read_byte(input bit host_ack, input string req);
    logic [7:0] got;
    logic [7:0] want;
    want = {exp_por, lock, 6'b0};
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(Q);
      scl_m = 1'b1; wait_n(H/2);
      got[i] = sda_bus;
      wait_n(H/2);
      scl_m = 1'b0; wait_n(Q);
    end
    chk(got == want, req, int'(got), int'(want));
    sda_m = host_ack ? 1'b0 : 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(H/2);
    chk(pull == 1'b0, "R9 released during host ack bit", int'(pull), 0);
    wait_n(H/2);
    scl_m = 1'b0; wait_n(Q);
    if (!host_ack) exp_por = por_ev ? 1'b1 : 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic pulse_por();
    por_ev = 1'b1; wait_n(1);
    por_ev = 1'b0; exp_por = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    // R12 reset state
    chk(pull == 1'b0, "R12 sda released in reset", int'(pull), 0);
    rst_n = 1'b1;
    wait_n(4);
    chk(div_word == 0 && ctrl == 0 && band == 0, "R12 registers zero",
        int'({div_word, ctrl, band}), 0);
    chk(pull == 1'b0, "R12 sda released after reset", int'(pull), 0);
    running = 1;

    // R2 R4 R5 R8: divider pair then control pair, address 1100_0100
    bus_start();
    write_byte(8'hC4, 1, 0, "R2 address ack");
    write_byte(8'h12, 1, 1, "R8 ack div1");
    write_byte(8'h34, 1, 1, "R8 ack div2");
    write_byte(8'hCA, 1, 1, "R8 ack ctrl");
    write_byte(8'h05, 1, 1, "R8 ack band");
    bus_stop();
    chk(div_word == 15'h1234, "R4 divider loaded", int'(div_word), 'h1234);
    chk(ctrl == 7'h4A && band == 3'h5, "R5 control loaded", int'({ctrl, band}), int'({7'h4A, 3'h5}));

    // R6: control first, then divider at the maximum value
    bus_start();
    write_byte(8'hC4, 1, 0, "R2 address ack");
    write_byte(8'h8F, 1, 1, "R8 ack ctrl");
    write_byte(8'h02, 1, 1, "R8 ack band");
    write_byte(8'h7F, 1, 1, "R8 ack div1");
    write_byte(8'hFF, 1, 1, "R8 ack div2");
    bus_stop();
    chk(div_word == 15'h7FFF, "R6 divider after control", int'(div_word), 'h7FFF);
    chk(ctrl == 7'h0F && band == 3'h2, "R6 control first", int'({ctrl, band}), int'({7'h0F, 3'h2}));

    // R6: divider-only and control-only telegrams
    bus_start();
    write_byte(8'hC4, 1, 0, "R2 address ack");
    write_byte(8'h01, 1, 1, "R8 ack div1");
    write_byte(8'h00, 1, 1, "R8 ack div2");
    bus_stop();
    chk(div_word == 15'h0100, "R6 divider only", int'(div_word), 'h100);
    bus_start();
    write_byte(8'hC4, 1, 0, "R2 address ack");
    write_byte(8'hF0, 1, 1, "R8 ack ctrl");
    write_byte(8'hFF, 1, 1, "R8 ack band");
    bus_stop();
    chk(ctrl == 7'h70 && band == 3'h7, "R6 control only", int'({ctrl, band}), int'({7'h70, 3'h7}));

    // R3: wrong address (A1A0=00 while pins give 10) is ignored
    bus_start();
    write_byte(8'hC0, 0, 0, "R3 no ack on mismatch");
    write_byte(8'h00, 0, 0, "R3 no ack after mismatch");
    write_byte(8'h00, 0, 0, "R3 no ack after mismatch");
    bus_stop();
    chk(div_word == 15'h0100, "R3 divider untouched", int'(div_word), 'h100);

    // R7: partial pair cut by stop
    bus_start();
    write_byte(8'hC4, 1, 0, "R2 address ack");
    write_byte(8'h05, 1, 1, "R8 ack div1");
    bus_stop();
    chk(div_word == 15'h0100, "R7 partial pair discarded", int'(div_word), 'h100);

    // R1 R7: partial pair cut by repeated start, then a fresh pair
    bus_start();
    write_byte(8'hC4, 1, 0, "R2 address ack");
    write_byte(8'h85, 1, 1, "R8 ack ctrl");
    bus_start();
    write_byte(8'hC4, 1, 0, "R1 address ack after repeated start");
    write_byte(8'h03, 1, 1, "R8 ack div1");
    write_byte(8'h21, 1, 1, "R8 ack div2");
    bus_stop();
    chk(div_word == 15'h0321, "R1 repeated start restarts pairing", int'(div_word), 'h321);
    chk(ctrl == 7'h70, "R7 control kept after cut pair", int'(ctrl), 'h70);

    // R2: other pin selection 01, address 1100_0010
    addr_sel = 2'b01;
    bus_start();
    write_byte(8'hC4, 0, 0, "R2 old address rejected");
    bus_start();
    write_byte(8'hC2, 1, 0, "R2 address ack sel01");
    write_byte(8'h2A, 1, 1, "R8 ack div1");
    write_byte(8'hAA, 1, 1, "R8 ack div2");
    bus_stop();
    chk(div_word == 15'h2AAA, "R2 write with sel01", int'(div_word), 'h2AAA);

    // R9 R10: read status, POR set after reset, repeated while acked
    bus_start();
    write_byte(8'hC3, 1, 0, "R2 read address ack");
    read_byte(1, "R9 status first byte");
    read_byte(1, "R9 status repeat");
    read_byte(0, "R9 status last byte");
    bus_stop();
    bus_start();
    lock = 1'b0;
    write_byte(8'hC3, 1, 0, "R2 read address ack");
    read_byte(0, "R10 POR cleared by finished read");
    bus_stop();

    // R10: undervoltage event sets the flag again
    pulse_por();
    lock = 1'b1;
    bus_start();
    write_byte(8'hC3, 1, 0, "R2 read address ack");
    read_byte(1, "R10 POR set by event");
    por_ev = 1'b1;
    read_byte(0, "R10 POR still set");
    por_ev = 1'b0;
    exp_por = 1;
    bus_stop();
    bus_start();
    write_byte(8'hC3, 1, 0, "R2 read address ack");
    read_byte(0, "R10 set wins over clear");
    bus_stop();
    bus_start();
    write_byte(8'hC3, 1, 0, "R2 read address ack");
    read_byte(0, "R10 cleared afterwards");
    bus_stop();
    chk(pull == 1'b0, "R9 released after read", int'(pull), 0);

    wait_n(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule